// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Unit

This block places three bidirectional pin ports on a small processor's byte-wide data-memory bus. Port A has 4 pins and ports B and C have 8 each. Every port has four registers: an output latch, a direction register, an input-threshold select and an active-low pull-up enable. The direction, threshold and pull-up registers are not given their own addresses. A separate 4-bit mode register selects which register set the writes to the three port addresses reach.

The pad side sees per-pin vectors for output value, output enable, threshold select and pull-up enable. It also returns the sampled pin levels. These levels pass through a two-flop synchronizer, and a bus read of a port returns them rather than the output latch. After reset every pin is a high-impedance input with TTL thresholds and the pull-up off.

Top module: `gpio_unit`

## Requirements
- R1: With the mode register in data selection, a write to address 05h, 06h or 07h updates the output latch of port A, B or C. Pins are packed into the pad vectors with A in bits 3:0, B in bits 11:4 and C in bits 19:12, and register bit n maps to pin n of its port.
- R2: `pad_oe` is 1 on a pin exactly when that pin's direction bit is 0. `pad_out` carries the latched level on an output pin and 0 on an input pin.
- R3: A read of 05h/06h/07h returns the level on that port's pins as sampled through two flops. A pin change is visible on `bus_rdata` after the second rising edge that follows it. The read never returns the latch contents.
- R4: Bits 7:4 of any read from port A are 0. Bits 7:4 of a write to port A have no effect on any pad output.
- R5: Reset is synchronous and active high. After reset all direction, threshold and pull-up bits are 1 and all latches are 0, so `pad_oe`=0, `pad_out`=0, `pad_ttl` is all ones and `pad_pu_n` is all ones. The mode register holds Fh, which is data selection.
- R6: With mode value 0, port writes load the pull-up register. A 0 bit enables the pull-up, and the bit appears on `pad_pu_n`. Latch and direction are left unchanged.
- R7: With mode value 1, port writes load the threshold register. A 0 bit selects CMOS levels and a 1 bit selects TTL levels, and the bit appears on `pad_ttl`. Latch and direction are left unchanged.
- R8: With mode value 2, port writes load the direction register. A 0 bit makes the pin an output and a 1 bit makes it an input.
- R9: Reads from any address other than 05h–07h return 00h. Writes to such addresses change no register.
- R10: Every mode value from 3 to 15 selects data access. The mode register is loaded from `mode_wdata` on a clock edge with `mode_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Data-memory address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe for port addresses |
| mode_wdata | input | 4 | New mode selector value |
| mode_we | input | 1 | Mode register write strobe |
| bus_rdata | output | 8 | Read data (combinational on address) |
| pad_in | input | 20 | Pin levels from the pads |
| pad_out | output | 20 | Output level per pin |
| pad_oe | output | 20 | Output enable per pin (1 = drive) |
| pad_ttl | output | 20 | Threshold select per pin (1 = TTL) |
| pad_pu_n | output | 20 | Pull-up enable per pin, active low |

## Verification
A bus or mode write lands on the rising edge where its strobe is high. The pad vectors then show the result one edge after the write, so the bench drives on falling edges and samples on the next falling edge. A pin change reaches `bus_rdata` only after two rising edges. The bench checks at one edge that the old value is still there and at two edges that the new value has arrived. Reads of unmapped addresses and of port A's upper bits are combinational on the address, and the bench samples them half a cycle after setting the address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NUM_PORTS = 3;

    typedef enum logic [1:0] {
        SEL_PULL   = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_DIR    = 2'd2,
        SEL_DATA   = 2'd3
    } reg_sel_e;

    localparam logic [3:0] MODE_RESET = 4'hF;

    function automatic reg_sel_e decode_mode(input logic [3:0] m);
        case (m)
            4'd0:    return SEL_PULL;
            4'd1:    return SEL_THRESH;
            4'd2:    return SEL_DIR;
            default: return SEL_DATA;
        endcase
    endfunction

    function automatic int port_width(input int idx, input int wa, input int wb, input int wc);
        return (idx == 0) ? wa : ((idx == 1) ? wb : wc);
    endfunction

    function automatic int port_lsb(input int idx, input int wa, input int wb);
        return (idx == 0) ? 0 : ((idx == 1) ? wa : wa + wb);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        stage1 <= d;
        stage2 <= stage1;
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pins_in,
    output logic [DW-1:0] rd_data,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_ttl,
    output logic [W-1:0]  pad_pu_n
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
        logic [W-1:0] ttl;
        logic [W-1:0] pu_n;
    } port_regs_t;

    port_regs_t   regs;
    logic [W-1:0] pins_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.lat  <= '0;
            regs.dir  <= '1;
            regs.ttl  <= '1;
            regs.pu_n <= '1;
        end else if (wr_en) begin
            case (sel)
                SEL_PULL:   regs.pu_n <= wdata;
                SEL_THRESH: regs.ttl  <= wdata;
                SEL_DIR:    regs.dir  <= wdata;
                default:    regs.lat  <= wdata;
            endcase
        end
    end

    gpio_sync #(.W(W)) u_sync (
        .clk (clk),
        .d   (pins_in),
        .q   (pins_sync)
    );

    always_comb begin
        rd_data         = '0;
        rd_data[W-1:0]  = pins_sync;
    end

    assign pad_oe   = ~regs.dir;
    assign pad_out  = regs.lat & ~regs.dir;
    assign pad_ttl  = regs.ttl;
    assign pad_pu_n = regs.pu_n;
endmodule

// File: rtl/gpio_unit.sv
module gpio_unit
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int MODE_W    = 4,
    parameter int PA_W      = 4,
    parameter int PB_W      = 8,
    parameter int PC_W      = 8,
    parameter int BASE_ADDR = 5,
    localparam int PIN_W    = PA_W + PB_W + PC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              mode_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_ttl,
    output logic [PIN_W-1:0]  pad_pu_n
);
    logic [MODE_W-1:0] mode_q;
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_arr [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MODE_W'(MODE_RESET);
        else if (mode_we) mode_q <= mode_wdata;
    end

    assign sel = decode_mode(4'(mode_q));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam int W  = port_width(i, PA_W, PB_W, PC_W);
        localparam int LO = port_lsb(i, PA_W, PB_W);
        localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(BASE_ADDR + i);

        logic wr_en;
        assign wr_en = bus_we && (bus_addr == ADDR);

        gpio_port #(.W(W), .DW(DATA_W)) u_port (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .sel      (sel),
            .wdata    (bus_wdata[W-1:0]),
            .pins_in  (pad_in[LO +: W]),
            .rd_data  (rd_arr[i]),
            .pad_out  (pad_out[LO +: W]),
            .pad_oe   (pad_oe[LO +: W]),
            .pad_ttl  (pad_ttl[LO +: W]),
            .pad_pu_n (pad_pu_n[LO +: W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (bus_addr == ADDR_W'(BASE_ADDR + i)) bus_rdata = rd_arr[i];
        end
    end
endmodule

// File: rtl/gpio_unit_chk.sv
module gpio_unit_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int MODE_W    = 4,
    parameter int PA_W      = 4,
    parameter int PB_W      = 8,
    parameter int PIN_W     = 20,
    parameter int BASE_ADDR = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [MODE_W-1:0] mode_q,
    input logic [PIN_W-1:0]  pad_in,
    input logic [PIN_W-1:0]  pad_out,
    input logic [PIN_W-1:0]  pad_oe,
    input logic [PIN_W-1:0]  pad_ttl,
    input logic [PIN_W-1:0]  pad_pu_n
);
    logic       rst_q;
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_state_R5: assert (pad_oe == '0 && pad_out == '0 &&
                                           pad_ttl == '1 && pad_pu_n == '1 &&
                                           mode_q == '1)
                else $error("reset state wrong");
        end
        if (rst === 1'b0) begin
            assert_out_only_when_enabled_R2: assert ((pad_out & ~pad_oe) == '0)
                else $error("pad_out driven on input pin");
            if (bus_addr == ADDR_W'(BASE_ADDR)) begin
                assert_porta_upper_zero_R4: assert (bus_rdata[DATA_W-1:PA_W] == '0)
                    else $error("port A upper read bits nonzero");
            end
            if (bus_addr < ADDR_W'(BASE_ADDR) || bus_addr > ADDR_W'(BASE_ADDR + 2)) begin
                assert_unmapped_zero_R9: assert (bus_rdata == '0)
                    else $error("unmapped read nonzero");
            end
        end
    end

    assert_cfg_write_keeps_pins_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && mode_q <= MODE_W'(1)) |=> ($stable(pad_out) && $stable(pad_oe)));

    assert_read_sync_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && bus_addr == ADDR_W'(BASE_ADDR + 1)) |->
        (bus_rdata[PB_W-1:0] == $past(pad_in[PA_W +: PB_W], 2)));
endmodule

bind gpio_unit gpio_unit_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MODE_W    (MODE_W),
    .PA_W      (PA_W),
    .PB_W      (PB_W),
    .PIN_W     (PIN_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_ttl   (pad_ttl),
    .pad_pu_n  (pad_pu_n)
);

// File: tb/tb_gpio_unit.sv
module tb_gpio_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_we = 1'b0;
    logic [3:0]  mode_wdata = 4'h0;
    logic        mode_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [19:0] pad_in = 20'h0;
    logic [19:0] pad_out, pad_oe, pad_ttl, pad_pu_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] m_lat [3];
    logic [7:0] m_dir [3];
    logic [7:0] m_ttl [3];
    logic [7:0] m_pu  [3];
    logic [3:0] m_mode;

    always #2 clk = ~clk;

    gpio_unit dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .mode_wdata(mode_wdata), .mode_we(mode_we),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_ttl(pad_ttl), .pad_pu_n(pad_pu_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] pack(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        return {c, b, a[3:0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_lat[i] = 8'h00; m_dir[i] = 8'hFF; m_ttl[i] = 8'hFF; m_pu[i] = 8'hFF;
        end
        m_mode = 4'hF;
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode_wdata = m; mode_we = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
        m_mode = m;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a >= 8'h05 && a <= 8'h07) begin
            case (m_mode)
                4'd0:    m_pu[a-5]  = d;
                4'd1:    m_ttl[a-5] = d;
                4'd2:    m_dir[a-5] = d;
                default: m_lat[a-5] = d;
            endcase
        end
    endtask

    task automatic check_pads(input string req);
        logic [19:0] e_oe, e_out, e_ttl, e_pu;
        e_oe  = ~pack(m_dir[0], m_dir[1], m_dir[2]);
        e_out = pack(m_lat[0], m_lat[1], m_lat[2]) & e_oe;
        e_ttl = pack(m_ttl[0], m_ttl[1], m_ttl[2]);
        e_pu  = pack(m_pu[0], m_pu[1], m_pu[2]);
        chk(pad_oe == e_oe,    {req, " pad_oe"},   32'(pad_oe),   32'(e_oe));
        chk(pad_out == e_out,  {req, " pad_out"},  32'(pad_out),  32'(e_out));
        chk(pad_ttl == e_ttl,  {req, " pad_ttl"},  32'(pad_ttl),  32'(e_ttl));
        chk(pad_pu_n == e_pu,  {req, " pad_pu_n"}, 32'(pad_pu_n), 32'(e_pu));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5: reset state
        check_pads("R5");

        // R1/R4/R8/R2: port A latch then every direction pattern
        wr(8'h05, 8'hA5);
        set_mode(4'd2);
        for (int d = 0; d < 16; d++) begin
            wr(8'h05, 8'(d) | 8'hF0);
            check_pads("R8 R2 R4 portA");
        end

        // R1/R2 on ports B and C across patterns
        for (int p = 0; p < 8; p++) begin
            logic [7:0] lv, dv;
            lv = 8'(p * 37 + 11);
            dv = 8'(p * 53 + 3);
            set_mode(4'hF);
            wr(8'h06, lv);
            wr(8'h07, ~lv);
            set_mode(4'd2);
            wr(8'h06, dv);
            wr(8'h07, ~dv);
            check_pads("R1 R2 portBC");
        end

        // R6: pull-up writes leave latch and direction alone
        set_mode(4'd0);
        wr(8'h05, 8'hF6);
        wr(8'h06, 8'h3C);
        wr(8'h07, 8'h81);
        check_pads("R6");

        // R7: threshold writes
        set_mode(4'd1);
        wr(8'h05, 8'h09);
        wr(8'h06, 8'h5A);
        wr(8'h07, 8'h0F);
        check_pads("R7");

        // R10: all modes 3..15 act as data access; B and C set to outputs
        set_mode(4'd2);
        wr(8'h06, 8'h00);
        wr(8'h07, 8'h00);
        for (int m = 3; m < 16; m++) begin
            set_mode(4'(m));
            wr(8'h06, 8'(m * 17));
            wr(8'h07, 8'(m * 29));
            check_pads("R10");
        end

        // R9: unmapped writes in data and config modes change nothing
        foreach (m_lat[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ua;
            ua = (k == 0) ? 8'h04 : (k == 1) ? 8'h08 : (k == 2) ? 8'h00 : 8'hFF;
            set_mode(4'hF);
            wr(ua, 8'h55);
            set_mode(4'd2);
            wr(ua, 8'hFF);
            check_pads("R9 write");
            @(negedge clk);
            pad_in = 20'hFFFFF;
            bus_addr = ua;
            repeat (3) @(negedge clk);
            chk(bus_rdata == 8'h00, "R9 read", 32'(bus_rdata), 32'h0);
        end

        // R3: port B read sweep, checking the two-edge latency
        set_mode(4'hF);
        @(negedge clk);
        bus_addr = 8'h06;
        pad_in = 20'h0;
        repeat (3) @(negedge clk);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] prev;
            prev = 8'(v - 1);
            if (v == 0) prev = 8'h00;
            pad_in[11:4] = 8'(v);
            @(negedge clk);
            chk(bus_rdata == prev, "R3 one-edge", 32'(bus_rdata), 32'(prev));
            @(negedge clk);
            chk(bus_rdata == 8'(v), "R3 two-edge", 32'(bus_rdata), 32'(v));
        end

        // R4/R3: port A read gives pins, upper bits zero, latch ignored
        @(negedge clk);
        bus_addr = 8'h05;
        for (int v = 0; v < 16; v++) begin
            pad_in[3:0]   = 4'(v);
            pad_in[19:12] = 8'hFF;
            repeat (2) @(negedge clk);
            chk(bus_rdata == 8'(v), "R4 R3 portA read", 32'(bus_rdata), 32'(v));
        end

        // R3: port C read differs from its latch
        @(negedge clk);
        bus_addr = 8'h07;
        pad_in[19:12] = ~m_lat[2];
        repeat (2) @(negedge clk);
        chk(bus_rdata == ~m_lat[2], "R3 portC pins not latch", 32'(bus_rdata), 32'(~m_lat[2]));

        // R5: reset after activity
        set_mode(4'd1);
        do_reset();
        check_pads("R5 second reset");
        wr(8'h06, 8'h3E);
        check_pads("R5 mode back to data");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule